// File: doc/BRIEF.md
# Mesh Next-Hop Port Selector

This unit decides which output port a packet leaves by in a router of a two-dimensional mesh. From the destination coordinates carried in a head flit and the router's own position, it forms signed offsets in X and Y. It then raises exactly one request among five ports: west, east, south, north and the local processor. The offsets only ever shrink, so every route is minimal.

A mode input picks one of two policies. In strict dimension-order mode, the X offset is reduced to zero before any Y hop is taken. In west-first mode, all westward travel comes first. Once a packet no longer needs to go west, the unit may trade between the productive east, north and south ports using congestion flags from the neighbours. This lets it steer around a busy link without ever turning back into west.

The decision is registered on the clock edge that samples the head flit. It is then held, unchanged, for the life of the packet. It drops in the cycle after the tail flit has been sampled.

Top module: `mesh_route_unit`

## Requirements
- R1: After reset `route_valid` is 0 and `port_req` is 5'b00000.
- R2: Encoding of `port_req`: bit0 west, bit1 east, bit2 south, bit3 north, bit4 local. With `mode`=0 (dimension order), a destination X below the router's X selects west and a destination X above it selects east, whatever Y is.
- R3: With `mode`=0 and equal X coordinates, a destination Y below the router's Y selects south and a destination Y above it selects north.
- R4: In either mode, when destination and router coordinates are equal in both X and Y, the local port is selected.
- R5: With `mode`=1 (west-first), a destination X below the router's X selects west regardless of Y and of all congestion flags.
- R6: With `mode`=1, when exactly one of east, north and south reduces the distance, that port is selected regardless of congestion flags.
- R7: With `mode`=1, when east and one Y port (north if the destination Y is above, south if below) are both productive, the port whose congestion flag is 0 is chosen. When both flags are equal, east is chosen.
- R8: A head flit accepted while no packet is in progress sets `route_valid` and its decision on `port_req` from the next clock edge on. The coordinates and flags are used only in the cycle of the head flit.
- R9: The decision holds for every flit of the packet and for one cycle after the tail flit is sampled, then `route_valid` and `port_req` clear. A head flit seen during a packet has no effect. A single-flit packet (head and tail together) keeps the decision for exactly one cycle.
- R10: Whenever `route_valid` is 1 exactly one bit of `port_req` is set, and whenever it is 0 `port_req` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| flit_valid | input | 1 | A flit is present this cycle |
| flit_head | input | 1 | Present flit is the first of its packet |
| flit_tail | input | 1 | Present flit is the last of its packet |
| dest_x | input | 4 | Destination X coordinate (head flit) |
| dest_y | input | 4 | Destination Y coordinate (head flit) |
| cur_x | input | 4 | This router's X coordinate |
| cur_y | input | 4 | This router's Y coordinate |
| mode | input | 1 | 0 dimension order, 1 west-first adaptive |
| cong_east | input | 1 | East neighbour reports congestion |
| cong_south | input | 1 | South neighbour reports congestion |
| cong_north | input | 1 | North neighbour reports congestion |
| route_valid | output | 1 | A decision is held for the current packet |
| port_req | output | 5 | One-hot output port request |

## Verification
Some rules are checked by assertions on every cycle. These are the one-hot or all-zero shape of the request, and that a decision stays stable while no head flit arrives. They also cover local delivery, westward travel before anything else, the X-before-Y choice of dimension-order mode, and that an accepted head flit raises the valid flag. Other behaviour is shown only by the bench's scenarios against its own reference function. That includes the congestion-based choice and the east preference on a tie in west-first mode, and the exact cycle at which the decision clears after the tail. It also includes the fact that head flits arriving mid-packet, with changed coordinates and flags, leave the held port untouched.

// File: rtl/mru_pkg.sv
package mru_pkg;
    localparam int NPORTS = 5;

    typedef enum int {
        P_W = 0,
        P_E = 1,
        P_S = 2,
        P_N = 3,
        P_L = 4
    } port_idx_e;

    typedef struct packed {
        logic xneg;
        logic xpos;
        logic yneg;
        logic ypos;
    } dir_t;

    typedef struct packed {
        logic              busy;
        logic              last;
        logic [NPORTS-1:0] port;
    } state_t;
endpackage

// File: rtl/mru_offset.sv
module mru_offset
    import mru_pkg::*;
#(
    parameter int COORD_W = 4
) (
    input  logic [COORD_W-1:0] dest_x,
    input  logic [COORD_W-1:0] dest_y,
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    output dir_t               dir
);
    localparam int OFF_W = COORD_W + 1;

    logic signed [OFF_W-1:0] dx;
    logic signed [OFF_W-1:0] dy;

    always_comb begin
        dx = $signed({1'b0, dest_x}) - $signed({1'b0, cur_x});
        dy = $signed({1'b0, dest_y}) - $signed({1'b0, cur_y});
        dir.xneg = dx[OFF_W-1];
        dir.xpos = !dx[OFF_W-1] && (dx != '0);
        dir.yneg = dy[OFF_W-1];
        dir.ypos = !dy[OFF_W-1] && (dy != '0);
    end
endmodule

// File: rtl/mru_xy.sv
module mru_xy
    import mru_pkg::*;
(
    input  dir_t              dir,
    output logic [NPORTS-1:0] req
);
    always_comb begin
        req = '0;
        if (dir.xneg)      req[P_W] = 1'b1;
        else if (dir.xpos) req[P_E] = 1'b1;
        else if (dir.yneg) req[P_S] = 1'b1;
        else if (dir.ypos) req[P_N] = 1'b1;
        else               req[P_L] = 1'b1;
    end
endmodule

// File: rtl/mru_westfirst.sv
module mru_westfirst
    import mru_pkg::*;
(
    input  dir_t              dir,
    input  logic              cong_e,
    input  logic              cong_s,
    input  logic              cong_n,
    output logic [NPORTS-1:0] req
);
    logic y_any;
    logic y_cong;
    logic take_y;

    always_comb begin
        y_any  = dir.yneg || dir.ypos;
        y_cong = dir.ypos ? cong_n : cong_s;
        // Y wins only when east is busy and the Y port is free
        take_y = cong_e && !y_cong;
        req    = '0;
        if (dir.xneg) begin
            req[P_W] = 1'b1;
        end else if (dir.xpos && y_any) begin
            if (take_y) begin
                req[P_N] = dir.ypos;
                req[P_S] = dir.yneg;
            end else begin
                req[P_E] = 1'b1;
            end
        end else if (dir.xpos) begin
            req[P_E] = 1'b1;
        end else if (dir.yneg) begin
            req[P_S] = 1'b1;
        end else if (dir.ypos) begin
            req[P_N] = 1'b1;
        end else begin
            req[P_L] = 1'b1;
        end
    end
endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit
    import mru_pkg::*;
#(
    parameter int COORD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flit_valid,
    input  logic               flit_head,
    input  logic               flit_tail,
    input  logic [COORD_W-1:0] dest_x,
    input  logic [COORD_W-1:0] dest_y,
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  logic               mode,
    input  logic               cong_east,
    input  logic               cong_south,
    input  logic               cong_north,
    output logic               route_valid,
    output logic [4:0]         port_req
);
    dir_t              dir;
    logic [NPORTS-1:0] xy_req;
    logic [NPORTS-1:0] wf_req;
    state_t            st_d, st_q;
    logic              accept;

    mru_offset #(.COORD_W(COORD_W)) off_i (
        .dest_x(dest_x), .dest_y(dest_y),
        .cur_x (cur_x),  .cur_y (cur_y),
        .dir   (dir)
    );

    mru_xy xy_i (.dir(dir), .req(xy_req));

    mru_westfirst wf_i (
        .dir   (dir),
        .cong_e(cong_east),
        .cong_s(cong_south),
        .cong_n(cong_north),
        .req   (wf_req)
    );

    always_comb begin
        st_d   = st_q;
        accept = flit_valid && flit_head && (!st_q.busy || st_q.last);
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.last = flit_tail;
            st_d.port = mode ? wf_req : xy_req;
        end else if (st_q.busy && st_q.last) begin
            st_d = '0;
        end else if (st_q.busy && flit_valid && flit_tail) begin
            st_d.last = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign route_valid = st_q.busy;
    assign port_req    = st_q.port;
endmodule

// File: rtl/mru_checker.sv
module mru_checker #(
    parameter int COORD_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flit_valid,
    input logic               flit_head,
    input logic [COORD_W-1:0] dest_x,
    input logic [COORD_W-1:0] dest_y,
    input logic [COORD_W-1:0] cur_x,
    input logic [COORD_W-1:0] cur_y,
    input logic               mode,
    input logic               route_valid,
    input logic [4:0]         port_req
);
    logic fresh_head;
    assign fresh_head = flit_valid && flit_head && !route_valid;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !route_valid |-> port_req == 5'b00000); // R10
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid |-> $countones(port_req) == 1); // R10
    AST_HOLD_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (route_valid && !(flit_valid && flit_head)) |=> (!route_valid || $stable(port_req))); // R9
    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        fresh_head |=> route_valid); // R8
    AST_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (fresh_head && dest_x == cur_x && dest_y == cur_y) |=> port_req == 5'b10000); // R4
    AST_WEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (fresh_head && dest_x < cur_x) |=> port_req == 5'b00001); // R5
    AST_XY_EAST: assert property (@(posedge clk) disable iff (!rst_n)
        (fresh_head && !mode && dest_x > cur_x) |=> port_req == 5'b00010); // R2
    AST_XY_NORTH: assert property (@(posedge clk) disable iff (!rst_n)
        (fresh_head && !mode && dest_x == cur_x && dest_y > cur_y) |=> port_req == 5'b01000); // R3
endmodule

bind mesh_route_unit mru_checker #(.COORD_W(COORD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid), .flit_head(flit_head),
    .dest_x(dest_x), .dest_y(dest_y), .cur_x(cur_x), .cur_y(cur_y),
    .mode(mode), .route_valid(route_valid), .port_req(port_req)
);

// File: tb/mesh_route_unit_tb.sv
module mesh_route_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flit_valid = 1'b0, flit_head = 1'b0, flit_tail = 1'b0;
    logic [3:0] dest_x = '0, dest_y = '0, cur_x = '0, cur_y = '0;
    logic       mode = 1'b0;
    logic       cong_east = 1'b0, cong_south = 1'b0, cong_north = 1'b0;
    logic       route_valid;
    logic [4:0] port_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mesh_route_unit dut_i (
        .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid), .flit_head(flit_head),
        .flit_tail(flit_tail), .dest_x(dest_x), .dest_y(dest_y), .cur_x(cur_x),
        .cur_y(cur_y), .mode(mode), .cong_east(cong_east), .cong_south(cong_south),
        .cong_north(cong_north), .route_valid(route_valid), .port_req(port_req)
    );

    function automatic logic [4:0] ref_route(logic m, int dx, int dy,
                                             logic ce, logic cs, logic cn);
        logic [4:0] ycand;
        logic       ycong;
        if (dx == 0 && dy == 0) return 5'b10000;
        if (dx < 0)             return 5'b00001;
        if (!m) begin
            if (dx > 0) return 5'b00010;
            return (dy < 0) ? 5'b00100 : 5'b01000;
        end
        ycand = (dy > 0) ? 5'b01000 : ((dy < 0) ? 5'b00100 : 5'b00000);
        ycong = (dy > 0) ? cn : cs;
        if (dx > 0 && ycand != 0) return (ce && !ycong) ? ycand : 5'b00010;
        if (dx > 0) return 5'b00010;
        return ycand;
    endfunction

    task automatic check(string req, logic av, logic [4:0] ap, logic ev, logic [4:0] ep);
        checks++;
        if (av !== ev || ap !== ep) begin
            errors++;
            $display("FAIL %s: valid/port actual %b/%b expected %b/%b", req, av, ap, ev, ep);
        end
    endtask

    task automatic send_pkt(string req, int len, logic m, logic [3:0] dx_i, logic [3:0] dy_i,
                            logic [3:0] cx, logic [3:0] cy, logic [2:0] cg, bit junk);
        logic [4:0] exp_p;
        exp_p = ref_route(m, int'(dx_i) - int'(cx), int'(dy_i) - int'(cy), cg[0], cg[1], cg[2]);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i > 0) check(req, route_valid, port_req, 1'b1, exp_p);
            flit_valid = 1'b1;
            flit_tail  = (i == len - 1);
            if (i == 0) begin
                flit_head = 1'b1;
                mode = m; dest_x = dx_i; dest_y = dy_i; cur_x = cx; cur_y = cy;
                {cong_north, cong_south, cong_east} = cg;
            end else begin
                // R9: mid-packet heads and changed inputs must be ignored
                flit_head = junk;
                mode = ~m; dest_x = $urandom; dest_y = $urandom;
                {cong_north, cong_south, cong_east} = $urandom;
            end
        end
        @(negedge clk);
        check(req, route_valid, port_req, 1'b1, exp_p);
        flit_valid = 1'b0; flit_head = 1'b0; flit_tail = 1'b0;
        @(negedge clk);
        check("R9 clear", route_valid, port_req, 1'b0, 5'b00000);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        check("R1", route_valid, port_req, 1'b0, 5'b00000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", route_valid, port_req, 1'b0, 5'b00000);

        send_pkt("R2", 3, 1'b0, 4'd0, 4'd15, 4'd15, 4'd0, 3'b000, 1'b1);
        send_pkt("R2", 2, 1'b0, 4'd15, 4'd0, 4'd0, 4'd15, 3'b111, 1'b0);
        send_pkt("R3", 2, 1'b0, 4'd5, 4'd0, 4'd5, 4'd15, 3'b000, 1'b0);
        send_pkt("R3", 1, 1'b0, 4'd5, 4'd9, 4'd5, 4'd8, 3'b000, 1'b0);
        send_pkt("R4", 1, 1'b0, 4'd7, 4'd7, 4'd7, 4'd7, 3'b111, 1'b0);
        send_pkt("R4", 3, 1'b1, 4'd0, 4'd0, 4'd0, 4'd0, 3'b111, 1'b1);
        send_pkt("R5", 2, 1'b1, 4'd2, 4'd9, 4'd3, 4'd1, 3'b111, 1'b1);
        send_pkt("R6", 2, 1'b1, 4'd9, 4'd4, 4'd1, 4'd4, 3'b001, 1'b0);
        send_pkt("R6", 2, 1'b1, 4'd4, 4'd1, 4'd4, 4'd9, 3'b010, 1'b0);
        send_pkt("R7", 2, 1'b1, 4'd9, 4'd9, 4'd1, 4'd1, 3'b001, 1'b0);
        send_pkt("R7", 2, 1'b1, 4'd9, 4'd0, 4'd1, 4'd5, 3'b001, 1'b0);
        send_pkt("R7", 2, 1'b1, 4'd9, 4'd0, 4'd1, 4'd5, 3'b011, 1'b0);
        send_pkt("R7", 2, 1'b1, 4'd9, 4'd9, 4'd1, 4'd1, 3'b100, 1'b0);
        send_pkt("R8", 1, 1'b1, 4'd9, 4'd9, 4'd1, 4'd1, 3'b000, 1'b0);

        for (int n = 0; n < 400; n++) begin
            send_pkt("R10 random", 1 + ($urandom % 4), 1'($urandom), 4'($urandom), 4'($urandom),
                     4'($urandom), 4'($urandom), 3'($urandom), 1'($urandom));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule